// File: doc/BRIEF.md
# Subaudible Tone Channel Decoder

This block identifies which standard subaudible squelch tone is present on a radio's audio path. It takes a squared-up version of the tone, counts its rising edges over a fixed gate window of roughly one second, and so obtains the tone frequency in whole hertz. That count is converted to a channel index through a non-uniform range table, because the standard tones are not evenly spaced. The index is then turned into two decimal digits by counting up a ones digit that carries into a tens digit.

Measurement runs continuously. When a conversion finishes, the digits are published together with a one-clock ready strobe, and a new gate window opens on the very next clock. Between strobes the published digits hold their value, so a display or a squelch comparator downstream can read them at any time. The gate length is a parameter given in clock cycles. The default is one second at 50 MHz.

Top module: `tone_chan_decoder`

## Requirements
- R1: The tone input passes through a two-stage synchroniser and a rising-edge detector. Each low-to-high transition adds exactly one to the edge count, however many clocks the input then stays high.
- R2: The gate window lasts GATE_CYCLES clocks. The edge count used for a result is the number of rising edges seen inside that window.
- R3: The 8-bit edge count saturates at 254. Any number of edges of 254 or more gives channel 50.
- R4: A count of zero bypasses the range table and gives the digits 0 and 0.
- R5: Counts map to channels through fixed ranges. Examples: counts 0 to 65 give channel 0, 66–67 give 1, 68–69 give 2, 70–72 give 3, 73–75 give 4, 99–101 give 13, 120–124 give 19, 125–128 give 20, 212–219 give 44, 220–226 give 45, 235–242 give 48, 243–251 give 49 and 252–254 give 50.
- R6: The channel index appears as two binary-coded decimal digits, tensOut and onesOut, each 0 to 9. They are built by incrementing the ones digit once per index unit: 9 wraps to 0 and carries into the tens digit, and the tens digit also wraps from 9 to 0.
- R7: readyOut is high for exactly one clock per result. New digit values appear on the outputs in that same clock.
- R8: tensOut and onesOut stay unchanged in every clock where readyOut is low.
- R9: The next gate window begins in the clock where readyOut is high. Edges that arrive from then on count toward the following result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| toneIn | input | 1 | Squared-up tone, asynchronous to clk |
| tensOut | output | 4 | Tens digit of the channel number (BCD) |
| onesOut | output | 4 | Ones digit of the channel number (BCD) |
| readyOut | output | 1 | One-clock pulse when new digits are published |

## Verification
The bench feeds a known number of tone pulses into each gate window. Counts are placed on both sides of several range boundaries (65/66, 72/73, 124/125, 219/220, 242/243), which separates an off-by-one table from a correct one. A count of zero checks the bypass. Counts of 254 and of 300 show that saturation holds the result at channel 50 and does not wrap. One run uses wide pulses, each held high for six clocks, to show that the count follows edges and not high levels. A run that gives channel 19 followed by one that gives channel 20 exercises the ones-to-tens carry. Sampling the digits in the middle of each gate checks that they hold their value.

// File: rtl/tone_chan_pkg.sv
package tone_chan_pkg;

  localparam int COUNT_W   = 8;
  localparam int COUNT_MAX = (1 << COUNT_W) - 2;
  localparam int CHAN_W    = 6;
  localparam int LAST_CHAN = 50;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic clrCount;
    logic cntEn;
    logic latchChan;
    logic stepDigit;
    logic publish;
  } dpCtrl_t;

  // highest edge count that still belongs to channel k
  function automatic logic [COUNT_W-1:0] chanUpper(input logic [CHAN_W-1:0] k);
    logic [COUNT_W-1:0] u;
    case (k)
      6'd0:  u = 8'd65;   6'd1:  u = 8'd67;   6'd2:  u = 8'd69;
      6'd3:  u = 8'd72;   6'd4:  u = 8'd75;   6'd5:  u = 8'd77;
      6'd6:  u = 8'd80;   6'd7:  u = 8'd83;   6'd8:  u = 8'd86;
      6'd9:  u = 8'd89;   6'd10: u = 8'd92;   6'd11: u = 8'd95;
      6'd12: u = 8'd98;   6'd13: u = 8'd101;  6'd14: u = 8'd105;
      6'd15: u = 8'd108;  6'd16: u = 8'd111;  6'd17: u = 8'd115;
      6'd18: u = 8'd119;  6'd19: u = 8'd124;  6'd20: u = 8'd128;
      6'd21: u = 8'd132;  6'd22: u = 8'd137;  6'd23: u = 8'd142;
      6'd24: u = 8'd147;  6'd25: u = 8'd152;  6'd26: u = 8'd157;
      6'd27: u = 8'd160;  6'd28: u = 8'd163;  6'd29: u = 8'd165;
      6'd30: u = 8'd168;  6'd31: u = 8'd171;  6'd32: u = 8'd174;
      6'd33: u = 8'd177;  6'd34: u = 8'd180;  6'd35: u = 8'd184;
      6'd36: u = 8'd187;  6'd37: u = 8'd190;  6'd38: u = 8'd193;
      6'd39: u = 8'd197;  6'd40: u = 8'd200;  6'd41: u = 8'd204;
      6'd42: u = 8'd207;  6'd43: u = 8'd211;  6'd44: u = 8'd219;
      6'd45: u = 8'd226;  6'd46: u = 8'd230;  6'd47: u = 8'd234;
      6'd48: u = 8'd242;  6'd49: u = 8'd251;
      default: u = 8'd254;
    endcase
    return u;
  endfunction

  // channel = number of range ceilings the count lies above
  function automatic logic [CHAN_W-1:0] countToChan(input logic [COUNT_W-1:0] c);
    logic [CHAN_W-1:0] n;
    n = '0;
    for (int k = 0; k < LAST_CHAN; k++) begin
      if (c > chanUpper(CHAN_W'(k))) n = n + 1'b1;
    end
    return n;
  endfunction

endpackage

// File: rtl/tcd_edge_sync.sv
module tcd_edge_sync (
  input  logic clk,
  input  logic rst,
  input  logic toneIn,
  output logic edgePulse
);

  logic syncA, syncB, lastB;

  always_ff @(posedge clk) begin
    if (rst) begin
      syncA <= 1'b0;
      syncB <= 1'b0;
      lastB <= 1'b0;
    end else begin
      syncA <= toneIn;
      syncB <= syncA;
      lastB <= syncB;
    end
  end

  assign edgePulse = syncB & ~lastB;

  // R1
  edge_single_chk: assert property (@(posedge clk) disable iff (rst)
    edgePulse |=> !edgePulse);

endmodule

// File: rtl/tcd_ctrl.sv
module tcd_ctrl
  import tone_chan_pkg::*;
#(
  parameter int GATE_CYCLES = 50_000_000
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    remZero,
  output dpCtrl_t ctl
);

  localparam int GW = $clog2(GATE_CYCLES + 1);
  localparam logic [GW-1:0] GATE_LAST = GW'(GATE_CYCLES - 1);

  typedef enum logic [1:0] {ST_GATE, ST_LOAD, ST_CONV, ST_DONE} seqState_t;

  seqState_t state, nextState;
  logic [GW-1:0] gateCnt;

  always_comb begin
    nextState = state;
    ctl = '0;
    unique case (state)
      ST_GATE: begin
        ctl.cntEn = 1'b1;
        if (gateCnt == GATE_LAST) nextState = ST_LOAD;
      end
      ST_LOAD: begin
        ctl.latchChan = 1'b1;
        nextState = ST_CONV;
      end
      ST_CONV: begin
        if (remZero) nextState = ST_DONE;
        else ctl.stepDigit = 1'b1;
      end
      ST_DONE: begin
        ctl.publish = 1'b1;
        ctl.clrCount = 1'b1;
        nextState = ST_GATE;
      end
      default: nextState = ST_GATE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_GATE;
      gateCnt <= '0;
    end else begin
      state <= nextState;
      if (state == ST_GATE && nextState == ST_GATE) gateCnt <= gateCnt + 1'b1;
      else gateCnt <= '0;
    end
  end

  // R9
  regate_chk: assert property (@(posedge clk) disable iff (rst)
    ctl.publish |=> (ctl.cntEn && gateCnt == '0));

  // R2
  gate_end_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl.cntEn && gateCnt == GATE_LAST) |=> ctl.latchChan);

endmodule

// File: rtl/tcd_datapath.sv
module tcd_datapath
  import tone_chan_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       edgePulse,
  input  dpCtrl_t    ctl,
  output logic       remZero,
  output logic [3:0] tensOut,
  output logic [3:0] onesOut,
  output logic       readyOut
);

  localparam logic [COUNT_W-1:0] SAT = COUNT_W'(COUNT_MAX);

  logic [COUNT_W-1:0] edgeCount;
  logic [CHAN_W-1:0]  remIdx;
  logic [3:0]         workTens, workOnes;

  // saturating edge counter
  always_ff @(posedge clk) begin
    if (rst || ctl.clrCount) edgeCount <= '0;
    else if (ctl.cntEn && edgePulse && edgeCount != SAT) edgeCount <= edgeCount + 1'b1;
  end

  // serial index-to-decimal conversion
  always_ff @(posedge clk) begin
    if (rst) begin
      remIdx <= '0;
      workTens <= '0;
      workOnes <= '0;
    end else if (ctl.latchChan) begin
      remIdx <= (edgeCount == '0) ? '0 : countToChan(edgeCount);
      workTens <= '0;
      workOnes <= '0;
    end else if (ctl.stepDigit) begin
      remIdx <= remIdx - 1'b1;
      if (workOnes == 4'd9) begin
        workOnes <= '0;
        workTens <= (workTens == 4'd9) ? 4'd0 : workTens + 4'd1;
      end else begin
        workOnes <= workOnes + 4'd1;
      end
    end
  end

  assign remZero = (remIdx == '0);

  // published result
  always_ff @(posedge clk) begin
    if (rst) begin
      tensOut <= '0;
      onesOut <= '0;
      readyOut <= 1'b0;
    end else begin
      readyOut <= ctl.publish;
      if (ctl.publish) begin
        tensOut <= workTens;
        onesOut <= workOnes;
      end
    end
  end

  // R3
  count_sat_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl.cntEn && edgeCount == SAT) |=> (edgeCount == SAT));

  // R4
  zero_bypass_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl.latchChan && edgeCount == '0) |=> remZero);

  // R6
  bcd_range_chk: assert property (@(posedge clk) disable iff (rst)
    (workOnes <= 4'd9) && (workTens <= 4'd9));

  // R7
  ready_width_chk: assert property (@(posedge clk) disable iff (rst)
    readyOut |=> !readyOut);

  // R8
  hold_digits_chk: assert property (@(posedge clk) disable iff (rst)
    !readyOut |-> ($stable(tensOut) && $stable(onesOut)));

endmodule

// File: rtl/tone_chan_decoder.sv
module tone_chan_decoder
  import tone_chan_pkg::*;
#(
  parameter int GATE_CYCLES = 50_000_000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       toneIn,
  output logic [3:0] tensOut,
  output logic [3:0] onesOut,
  output logic       readyOut
);

  logic    edgePulse;
  logic    remZero;
  dpCtrl_t ctl;

  tcd_edge_sync uSync (
    .clk       (clk),
    .rst       (rst),
    .toneIn    (toneIn),
    .edgePulse (edgePulse)
  );

  tcd_ctrl #(.GATE_CYCLES(GATE_CYCLES)) uCtrl (
    .clk     (clk),
    .rst     (rst),
    .remZero (remZero),
    .ctl     (ctl)
  );

  tcd_datapath uDp (
    .clk       (clk),
    .rst       (rst),
    .edgePulse (edgePulse),
    .ctl       (ctl),
    .remZero   (remZero),
    .tensOut   (tensOut),
    .onesOut   (onesOut),
    .readyOut  (readyOut)
  );

endmodule

// File: tb/sim_tone_chan_decoder.sv
`timescale 1ns/1ps
module sim_tone_chan_decoder;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic toneIn = 1'b0;
  logic [3:0] tensOut, onesOut;
  logic readyOut;

  int total = 0;
  int fails = 0;
  int prevChan = 0;

  always #10 clk = ~clk;

  tone_chan_decoder #(.GATE_CYCLES(1400)) u0 (
    .clk(clk), .rst(rst), .toneIn(toneIn),
    .tensOut(tensOut), .onesOut(onesOut), .readyOut(readyOut)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  // waits at negedges until readyOut is seen high
  task automatic waitReady(input string req);
    int n = 0;
    while (readyOut !== 1'b1 && n < 4000) begin
      @(negedge clk);
      n++;
    end
    if (readyOut !== 1'b1) chk(req, "ready timeout", 0, 1);
  endtask

  // one gate: called at the negedge where readyOut is high
  task automatic measure(input string req, input int pulses, input int highLen, input int expChan);
    @(negedge clk);
    chk("R7", "ready width", int'(readyOut), 0);
    repeat (2) @(negedge clk);
    for (int i = 0; i < pulses; i++) begin
      toneIn = 1'b1;
      repeat (highLen) @(negedge clk);
      toneIn = 1'b0;
      repeat (2) @(negedge clk);
    end
    // R8: digits still hold the previous result in mid gate
    chk("R8", "held value", int'(tensOut) * 10 + int'(onesOut), prevChan);
    waitReady(req);
    chk(req, "tens digit", int'(tensOut), expChan / 10);
    chk(req, "ones digit", int'(onesOut), expChan % 10);
    prevChan = expChan;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // reset state
    chk("R7", "ready in reset", int'(readyOut), 0);
    chk("R6", "digits in reset", int'(tensOut) * 10 + int'(onesOut), 0);
    rst = 1'b0;
    waitReady("R4");
    // R4: the empty first gate gives 00
    chk("R4", "zero tens", int'(tensOut), 0);
    chk("R4", "zero ones", int'(onesOut), 0);
    measure("R5", 66, 2, 1);      // lower edge of channel 1
    measure("R5", 65, 2, 0);      // top of channel 0
    measure("R5", 72, 2, 3);
    measure("R5", 73, 2, 4);
    measure("R1", 70, 6, 3);      // wide pulses count once each
    measure("R6", 124, 2, 19);
    measure("R6", 125, 2, 20);    // ones carry into tens
    measure("R5", 100, 2, 13);
    measure("R5", 219, 2, 44);
    measure("R5", 220, 2, 45);
    measure("R5", 242, 2, 48);
    measure("R5", 243, 2, 49);
    measure("R3", 254, 2, 50);
    measure("R3", 300, 2, 50);    // saturation, no wrap
    measure("R9", 0, 2, 0);       // back-to-back gate with no edges
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

endmodule